// File: doc/BRIEF.md
# Byte-Sequencing Two-Wire Bus Controller with Data Queues

This block is the controller side of a two-wire serial bus (I2C). Software sets it up through a small 32-bit register port. It loads outgoing bytes into a transmit queue and names the target and the direction. It writes a byte count and then raises a start bit. The controller then puts on the bus a start condition, the address byte, and the counted data bytes, each with its acknowledge slot. If no hold is requested it closes with a stop condition.

Incoming bytes go into a receive queue, and software drains that queue through the register port. The controller paces every bus phase from an external `tick` pulse that a separate timing block supplies. If a queue cannot keep up, the controller parks the bus with the clock line low and does not abandon the transfer.

A single interrupt line serves three kinds of event: the end of a transfer, a refused byte, and a queue crossing a level that software programs.

Top module: `i2c_fifo_master`

## Requirements
- R1: A transfer begins only when control bit 0 changes from 0 to 1 while control bit 2 (enable) is 1. Status bit 0 (busy) is 1 for the whole transfer. A start bit that is already 1, or that rises while enable is 0, begins nothing.
- R2: The wire sequence is as follows. First comes a start condition. Next comes the address byte, built from register 0x04 bits 7:1 with control bit 3 (1 = read) in bit 0. Then come exactly the number of data bytes held in register 0x08. All bytes are sent most significant bit first, and each byte is followed by one acknowledge slot.
- R3: A write of data to offset 0x10 adds that byte to the transmit queue, which is 16 deep. Status bit 3 is 1 exactly when the transmit queue is empty.
- R4: A read at offset 0x0c returns the oldest received byte and removes it from the queue. During a read transfer the controller acknowledges (SDA low) every byte except the last counted one, which it refuses (SDA high).
- R5: When control bit 20 is 0, a stop condition follows the last byte. When it is 1, no stop is sent and SCL is left low, so a repeated start can follow.
- R6: If the target refuses a byte, status bit 1 is set. The controller sends a stop, ends the transfer, and sends none of the remaining bytes.
- R7: At the end of each transfer status bit 2 (interrupt pending) is set. The `irq` output equals status bit 2 ANDed with control bit 1.
- R8: Writing offset 0x14 with a 0 in bit 2 or bit 1 clears that flag. Writing a 1 there leaves the flag as it was.
- R9: The interrupt-pending flag is also set in two level cases. One is when control bit 9 is 1 and the transmit-queue level is at or below control bits 15:12. The other is when control bit 10 is 1 and the receive-queue level is at or above control bits 19:16.
- R10: If a write transfer finds the transmit queue empty, or a read transfer finds the receive queue full, the controller holds SCL low and waits. It resumes when a byte is pushed or popped.
- R11: Writing 1 to bit 0 of offset 0x2c empties both queues.
- R12: Status bit 20 shows the SCL input and status bit 21 shows the SDA input. After reset the status register reads 0x00300008.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at 0x0c) |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| irq | output | 1 | Interrupt request |
| tick | input | 1 | One-cycle pulse that ends the current bus phase |
| scl_o | output | 1 | SCL drive: 0 pulls low, 1 releases |
| sda_o | output | 1 | SDA drive: 0 pulls low, 1 releases |
| scl_i | input | 1 | SCL level on the bus |
| sda_i | input | 1 | SDA level on the bus |

## Verification
A register write takes effect at the next clock edge. A start trigger moves the engine out of idle one edge later, and the flags set by completion or a refusal appear one edge after the engine reports the event.

Register reads are combinational, so the bench samples `reg_rdata` inside the read strobe, away from the edge. Bus timing depends on the external tick, so the bench does not count cycles to the end of a transfer. It polls the busy bit instead, and for stalls it waits well past the point where the bus must park.

Wire bytes are compared one at a time, at the falling clock edge that ends each eighth bit, against a queue of expected values that the stimulus tasks fill.

// File: rtl/i2cm_pkg.sv
// Shared types and register offsets for the two-wire bus controller.
package i2cm_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_BIT   = 2'd1,
        OP_STOP  = 2'd2
    } phy_op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_ABIT, S_AACK, S_WLOAD, S_WBIT, S_WACK,
        S_RWAIT, S_RBIT, S_RACK, S_STOP, S_DONE
    } eng_state_e;

    localparam logic [5:0] OFS_CTL   = 6'h00;
    localparam logic [5:0] OFS_TGT   = 6'h04;
    localparam logic [5:0] OFS_CNT   = 6'h08;
    localparam logic [5:0] OFS_RXD   = 6'h0C;
    localparam logic [5:0] OFS_TXD   = 6'h10;
    localparam logic [5:0] OFS_STAT  = 6'h14;
    localparam logic [5:0] OFS_FLUSH = 6'h2C;

endpackage

// File: rtl/i2cm_fifo.sv
// Synchronous byte queue with level output and a flush input.
// Assumes DEPTH is a power of two and that callers never push when full
// or pop when empty.
module i2cm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH):0]     level,
    output logic                       empty,
    output logic                       full
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [LW-1:0] cnt;

    // Storage write.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            cnt <= cnt + LW'(push) - LW'(pop);
        end
    end

    assign rdata = mem[rp];
    assign level = cnt;
    assign empty = (cnt == '0);
    assign full  = (cnt == LW'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);  // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);  // R4
endmodule

// File: rtl/i2cm_bit_phy.sv
// Bus-phase sequencer: runs one start, one data bit or one stop per
// command, advancing a phase on each external tick. It keeps its line
// drive between commands, so SCL stays low after a start or a bit.
// Assumes op_go is only raised while busy is low.
module i2cm_bit_phy
    import i2cm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    input  logic    op_go,
    input  phy_op_e op_kind,
    input  logic    op_bit,
    input  logic    sda_i,
    output logic    busy,
    output logic    done,
    output logic    rx_bit,
    output logic    scl_o,
    output logic    sda_o
);
    phy_op_e    kind_q;
    logic       bit_q;
    logic [1:0] ph;

    // Line levels {scl, sda} for a given command phase.
    function automatic logic [1:0] drive(phy_op_e k, logic [1:0] p, logic b);
        case (k)
            OP_START: case (p)
                2'd0:    drive = 2'b01;
                2'd1:    drive = 2'b11;
                2'd2:    drive = 2'b10;
                default: drive = 2'b00;
            endcase
            OP_BIT:   drive = {p[0], b};
            default:  case (p)
                2'd0:    drive = 2'b00;
                2'd1:    drive = 2'b10;
                default: drive = 2'b11;
            endcase
        endcase
    endfunction

    // Index of the final phase of each command.
    function automatic logic [1:0] last_ph(phy_op_e k);
        case (k)
            OP_START: last_ph = 2'd3;
            OP_BIT:   last_ph = 2'd1;
            default:  last_ph = 2'd2;
        endcase
    endfunction

    // Phase stepping, line drive and bit sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            rx_bit <= 1'b0;
            ph     <= '0;
            kind_q <= OP_STOP;
            bit_q  <= 1'b1;
            scl_o  <= 1'b1;
            sda_o  <= 1'b1;
        end else begin
            done <= 1'b0;
            if (!busy && op_go) begin
                busy   <= 1'b1;
                kind_q <= op_kind;
                bit_q  <= op_bit;
                ph     <= '0;
                {scl_o, sda_o} <= drive(op_kind, 2'd0, op_bit);
            end else if (busy && tick) begin
                if (ph == last_ph(kind_q)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    if (kind_q == OP_BIT) begin
                        rx_bit <= sda_i;
                        scl_o  <= 1'b0;
                    end
                end else begin
                    ph <= ph + 2'd1;
                    {scl_o, sda_o} <= drive(kind_q, ph + 2'd1, bit_q);
                end
            end
        end
    end

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);  // R2
endmodule

// File: rtl/i2cm_engine.sv
// Byte sequencer: start, address byte, data bytes with acknowledge
// slots, then an optional stop. It parks the bus (SCL low) while a
// queue is not ready. Issues one phy command at a time and waits for
// its done pulse before moving on.
module i2cm_engine
    import i2cm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [7:0]       tgt_byte,
    input  logic             dir_rd,
    input  logic [CNT_W-1:0] count,
    input  logic             hold,
    input  logic             tx_empty,
    input  logic [7:0]       tx_data,
    output logic             tx_pop,
    input  logic             rx_full,
    output logic             rx_push,
    output logic [7:0]       rx_data,
    input  logic             phy_busy,
    input  logic             phy_done,
    input  logic             phy_rx,
    output logic             op_go,
    output phy_op_e          op_kind,
    output logic             op_bit,
    output logic             busy,
    output logic             stalled,
    output logic             ev_done,
    output logic             ev_nack
);
    eng_state_e       st;
    logic [7:0]       sh;
    logic [2:0]       bitcnt;
    logic [CNT_W-1:0] rem;
    logic             dir_q;
    logic             issued;
    logic             need_op;

    // State that follows an acknowledged byte, given the bytes left.
    function automatic eng_state_e after(logic [CNT_W-1:0] r, logic h, logic d);
        if (r == '0)  after = h ? S_DONE : S_STOP;
        else if (d)   after = S_RWAIT;
        else          after = S_WLOAD;
    endfunction

    // Command selection for the current state.
    always_comb begin
        need_op = (st == S_START) || (st == S_ABIT) || (st == S_AACK) ||
                  (st == S_WBIT)  || (st == S_WACK) || (st == S_RBIT) ||
                  (st == S_RACK)  || (st == S_STOP);
        op_kind = (st == S_START) ? OP_START : (st == S_STOP) ? OP_STOP : OP_BIT;
        case (st)
            S_ABIT, S_WBIT: op_bit = sh[7];
            S_RACK:         op_bit = (rem == CNT_W'(1));
            default:        op_bit = 1'b1;
        endcase
    end

    assign op_go   = need_op && !issued && !phy_busy;
    assign tx_pop  = (st == S_WLOAD) && !tx_empty;
    assign rx_push = (st == S_RBIT) && phy_done && (bitcnt == 3'd7);
    assign rx_data = {sh[6:0], phy_rx};
    assign busy    = (st != S_IDLE);
    assign stalled = (st == S_WLOAD && tx_empty) || (st == S_RWAIT && rx_full);
    assign ev_done = (st == S_DONE);

    // Sequencing of the transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            sh      <= '0;
            bitcnt  <= '0;
            rem     <= '0;
            dir_q   <= 1'b0;
            issued  <= 1'b0;
            ev_nack <= 1'b0;
        end else begin
            ev_nack <= 1'b0;
            if (op_go)    issued <= 1'b1;
            if (phy_done) issued <= 1'b0;
            case (st)
                S_IDLE: if (go) begin
                    st     <= S_START;
                    dir_q  <= dir_rd;
                    rem    <= count;
                    sh     <= {tgt_byte[7:1], dir_rd};
                    bitcnt <= '0;
                end
                S_START: if (phy_done) st <= S_ABIT;
                S_ABIT, S_WBIT: if (phy_done) begin
                    sh     <= {sh[6:0], 1'b0};
                    bitcnt <= bitcnt + 3'd1;
                    if (bitcnt == 3'd7) st <= (st == S_ABIT) ? S_AACK : S_WACK;
                end
                S_AACK: if (phy_done) begin
                    if (phy_rx) begin
                        ev_nack <= 1'b1;
                        st      <= S_STOP;
                    end else begin
                        st <= after(rem, hold, dir_q);
                    end
                end
                S_WLOAD: if (!tx_empty) begin
                    sh     <= tx_data;
                    bitcnt <= '0;
                    st     <= S_WBIT;
                end
                S_WACK: if (phy_done) begin
                    if (phy_rx) begin
                        ev_nack <= 1'b1;
                        st      <= S_STOP;
                    end else begin
                        rem <= rem - 1'b1;
                        st  <= after(rem - 1'b1, hold, dir_q);
                    end
                end
                S_RWAIT: if (!rx_full) begin
                    bitcnt <= '0;
                    st     <= S_RBIT;
                end
                S_RBIT: if (phy_done) begin
                    sh     <= {sh[6:0], phy_rx};
                    bitcnt <= bitcnt + 3'd1;
                    if (bitcnt == 3'd7) st <= S_RACK;
                end
                S_RACK: if (phy_done) begin
                    rem <= rem - 1'b1;
                    st  <= after(rem - 1'b1, hold, dir_q);
                end
                S_STOP: if (phy_done) st <= S_DONE;
                default: st <= S_IDLE;
            endcase
        end
    end

    AST_RX_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);  // R10
    AST_ONE_OP_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        op_go |-> !phy_busy);  // R2
endmodule

// File: rtl/i2c_fifo_master.sv
// Top of the two-wire bus controller: register port, the two byte
// queues, interrupt flags, the byte sequencer and the phase sequencer.
// Assumes an external timing block pulses tick once per bus phase and
// that the pads turn scl_o/sda_o = 0 into a pulled-low line.
module i2c_fifo_master
    import i2cm_pkg::*;
#(
    parameter int Q_DEPTH = 16,
    parameter int CNT_W   = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [5:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    input  logic        tick,
    output logic        scl_o,
    output logic        sda_o,
    input  logic        scl_i,
    input  logic        sda_i
);
    localparam int LW = $clog2(Q_DEPTH) + 1;

    // Control fields.
    logic             c_start, c_ie, c_en, c_dir, c_aeie, c_afie, c_hold;
    logic [3:0]       c_ael, c_afl;
    logic [7:0]       tgt_q;
    logic [CNT_W-1:0] cnt_q;
    logic             start_q, st_pend, st_nack;

    // Queue and engine wiring.
    logic          tx_push, tx_pop, tx_empty, tx_full;
    logic [7:0]    tx_data;
    logic [LW-1:0] tx_lvl;
    logic          rx_push, rx_pop, rx_empty, rx_full;
    logic [7:0]    rx_wdata, rx_data;
    logic [LW-1:0] rx_lvl;
    logic          flush, go;
    logic          eng_busy, stalled, ev_done, ev_nack;
    logic          op_go, op_bit, phy_busy, phy_done, phy_rx;
    phy_op_e       op_kind;
    logic          lvl_hit, unused_bits;

    assign flush   = reg_wr && reg_addr == OFS_FLUSH && reg_wdata[0];
    assign tx_push = reg_wr && reg_addr == OFS_TXD && !tx_full;
    assign rx_pop  = reg_rd && reg_addr == OFS_RXD && !rx_empty;
    assign go      = c_start && !start_q && c_en && !eng_busy;
    assign lvl_hit = (c_aeie && tx_lvl <= LW'(c_ael)) ||
                     (c_afie && rx_lvl >= LW'(c_afl));
    assign irq     = st_pend && c_ie;
    assign unused_bits = ^{reg_wdata[31:21], reg_wdata[11], reg_wdata[8:4]};

    // Configuration registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {c_start, c_ie, c_en, c_dir, c_aeie, c_afie, c_hold} <= '0;
            c_ael <= '0;
            c_afl <= '0;
            tgt_q <= '0;
            cnt_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_CTL: begin
                    c_start <= reg_wdata[0];
                    c_ie    <= reg_wdata[1];
                    c_en    <= reg_wdata[2];
                    c_dir   <= reg_wdata[3];
                    c_aeie  <= reg_wdata[9];
                    c_afie  <= reg_wdata[10];
                    c_ael   <= reg_wdata[15:12];
                    c_afl   <= reg_wdata[19:16];
                    c_hold  <= reg_wdata[20];
                end
                OFS_TGT: tgt_q <= reg_wdata[7:0];
                OFS_CNT: cnt_q <= reg_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // Start-edge history and sticky flags (write zero to clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            st_pend <= 1'b0;
            st_nack <= 1'b0;
        end else begin
            start_q <= c_start;
            if (reg_wr && reg_addr == OFS_STAT) begin
                st_pend <= (st_pend && reg_wdata[2]) || ev_done || ev_nack || lvl_hit;
                st_nack <= (st_nack && reg_wdata[1]) || ev_nack;
            end else begin
                st_pend <= st_pend || ev_done || ev_nack || lvl_hit;
                st_nack <= st_nack || ev_nack;
            end
        end
    end

    // Register read mux.
    always_comb begin
        case (reg_addr)
            OFS_CTL:  reg_rdata = {11'd0, c_hold, c_afl, c_ael, 1'b0, c_afie,
                                   c_aeie, 5'd0, c_dir, c_en, c_ie, c_start};
            OFS_TGT:  reg_rdata = {24'd0, tgt_q};
            OFS_CNT:  reg_rdata = {{(32-CNT_W){1'b0}}, cnt_q};
            OFS_RXD:  reg_rdata = {24'd0, rx_data};
            OFS_STAT: reg_rdata = {10'd0, sda_i, scl_i, 15'd0, rx_full, tx_empty,
                                   st_pend, st_nack, eng_busy};
            default:  reg_rdata = {31'd0, unused_bits & 1'b0};
        endcase
    end

    i2cm_fifo #(.W(8), .DEPTH(Q_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(tx_push),
        .wdata(reg_wdata[7:0]), .pop(tx_pop), .rdata(tx_data),
        .level(tx_lvl), .empty(tx_empty), .full(tx_full)
    );

    i2cm_fifo #(.W(8), .DEPTH(Q_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(rx_push),
        .wdata(rx_wdata), .pop(rx_pop), .rdata(rx_data),
        .level(rx_lvl), .empty(rx_empty), .full(rx_full)
    );

    i2cm_engine #(.CNT_W(CNT_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .go(go), .tgt_byte(tgt_q), .dir_rd(c_dir),
        .count(cnt_q), .hold(c_hold), .tx_empty(tx_empty), .tx_data(tx_data),
        .tx_pop(tx_pop), .rx_full(rx_full), .rx_push(rx_push),
        .rx_data(rx_wdata), .phy_busy(phy_busy), .phy_done(phy_done),
        .phy_rx(phy_rx), .op_go(op_go), .op_kind(op_kind), .op_bit(op_bit),
        .busy(eng_busy), .stalled(stalled), .ev_done(ev_done), .ev_nack(ev_nack)
    );

    i2cm_bit_phy u_phy (
        .clk(clk), .rst_n(rst_n), .tick(tick), .op_go(op_go),
        .op_kind(op_kind), .op_bit(op_bit), .sda_i(sda_i), .busy(phy_busy),
        .done(phy_done), .rx_bit(phy_rx), .scl_o(scl_o), .sda_o(sda_o)
    );

    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_busy) |-> $past(c_en));  // R1
    AST_DONE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |=> st_pend);  // R7
    AST_NACK_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nack |=> st_nack);  // R6
    AST_STALL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        stalled |-> !scl_o);  // R10
endmodule

// File: tb/tb_i2c_fifo_master.sv
`timescale 1ns/1ps
module tb_i2c_fifo_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, tick = 1'b0, scl_o, sda_o, scl_i, sda_i;
    logic        s_sda = 1'b1;

    localparam logic [31:0] K_START = 32'h1, K_IE = 32'h2, K_EN = 32'h4,
                            K_RD = 32'h8, K_AEIE = 32'h200, K_AFIE = 32'h400,
                            K_HOLD = 32'h100000;

    int n_chk = 0, n_bad = 0;
    byte unsigned exp_q[$];
    byte unsigned rd_q[$];
    int           ack_q[$];
    int           nack_idx = -1;
    int           stop_cnt = 0;

    assign scl_i = scl_o;
    assign sda_i = sda_o & s_sda;

    always #2.5 clk = ~clk;

    i2c_fifo_master dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .tick(tick), .scl_o(scl_o), .sda_o(sda_o),
        .scl_i(scl_i), .sda_i(sda_i)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // Driver: queue a data byte and its expected appearance on the wire.
    task automatic send_byte(input byte unsigned b);
        wr(6'h10, {24'd0, b});
        exp_q.push_back(b);
    endtask

    task automatic run(input logic [31:0] c);
        wr(6'h00, c);
        wr(6'h00, c | K_START);
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] s;
        int i;
        repeat (4) @(negedge clk);
        s = 32'h1;
        for (i = 0; i < 5000 && s[0]; i++) rd(6'h14, s);
        chk(req, int'(s[0]), 0);
    endtask

    // Tick source: one pulse every four clocks.
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    // Target model and monitor: compares wire bytes against exp_q.
    initial begin
        logic pscl, psda, scl, sda, active, reading, macked;
        int bitcnt, byte_idx;
        byte unsigned sh, cur;
        pscl = 1; psda = 1; active = 0; reading = 0; macked = 0;
        bitcnt = 0; byte_idx = 0; sh = 0; cur = 0;
        forever begin
            @(negedge clk);
            scl = scl_i; sda = sda_i;
            if (pscl && scl && psda && !sda) begin
                active = 1; bitcnt = 0; byte_idx = 0; reading = 0; s_sda = 1;
            end else if (pscl && scl && !psda && sda) begin
                stop_cnt++; active = 0;
            end else if (active && !pscl && scl) begin
                if (bitcnt < 8) begin
                    sh = {sh[6:0], sda}; bitcnt++;
                end else if (bitcnt == 8) begin
                    if (reading && byte_idx > 0) begin
                        macked = sda;
                        if (ack_q.size() == 0) chk("R4 unexpected ack slot", 1, 0);
                        else chk("R4 master ack bit", int'(sda), ack_q.pop_front());
                    end
                    bitcnt = 9;
                end
            end else if (active && pscl && !scl) begin
                if (bitcnt == 8) begin
                    if (byte_idx == 0 || !reading) begin
                        if (byte_idx == 0) reading = sh[0];
                        if (exp_q.size() == 0) chk("R2 unexpected wire byte", int'(sh), -1);
                        else chk("R2 wire byte", int'(sh), int'(exp_q.pop_front()));
                        s_sda = (byte_idx == nack_idx) ? 1'b1 : 1'b0;
                    end else begin
                        s_sda = 1;
                    end
                end else if (bitcnt == 9) begin
                    byte_idx++; bitcnt = 0;
                    if (reading && (byte_idx == 1 || !macked) && rd_q.size() > 0) begin
                        cur = rd_q.pop_front(); s_sda = cur[7];
                    end else begin
                        s_sda = 1;
                    end
                end else if (bitcnt >= 1 && bitcnt <= 7 && reading && byte_idx > 0) begin
                    s_sda = cur[7 - bitcnt];
                end
            end
            pscl = scl; psda = sda;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        logic [31:0] s;
        int sc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R12, R3)
        rd(6'h14, s);
        chk("R12 status after reset", int'(s), 32'h0030_0008);
        chk("R7 irq after reset", int'(irq), 0);

        // R1: rising start without enable, then a start that stays high
        wr(6'h00, K_START);
        repeat (3) @(negedge clk);
        rd(6'h14, s); chk("R1 no start without enable", int'(s[0]), 0);
        wr(6'h00, K_EN | K_START);
        repeat (3) @(negedge clk);
        rd(6'h14, s); chk("R1 no start without 0-to-1 edge", int'(s[0]), 0);
        wr(6'h00, 32'h0);

        // Write of three bytes with stop (R2, R3, R5, R7, R8)
        wr(6'h04, 32'hA0); wr(6'h08, 32'd3);
        exp_q.push_back(8'hA0);
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
        rd(6'h14, s); chk("R3 tx not empty after pushes", int'(s[3]), 0);
        run(K_EN | K_IE);
        repeat (3) @(negedge clk);
        rd(6'h14, s); chk("R1 busy during transfer", int'(s[0]), 1);
        wait_idle("R1 busy clears");
        chk("R5 stop after write", stop_cnt, 1);
        rd(6'h14, s); chk("R7 pending after done", int'(s[4:0]), 5'h0C);
        chk("R7 irq asserted", int'(irq), 1);
        wr(6'h14, 32'h4);
        rd(6'h14, s); chk("R8 write one keeps pending", int'(s[2]), 1);
        wr(6'h14, 32'h0);
        rd(6'h14, s); chk("R8 write zero clears pending", int'(s[4:0]), 5'h08);
        chk("R7 irq drops", int'(irq), 0);

        // Read of three bytes (R2, R4, R9 almost-full)
        wr(6'h04, 32'h42);
        exp_q.push_back(8'h43);
        rd_q.push_back(8'h5A); rd_q.push_back(8'hC3); rd_q.push_back(8'h0F);
        ack_q.push_back(0); ack_q.push_back(0); ack_q.push_back(1);
        run(K_EN | K_IE | K_RD);
        wait_idle("R2 read completes");
        chk("R5 stop after read", stop_cnt, 2);
        wr(6'h00, K_EN | K_IE | K_AFIE | (32'd5 << 16));
        wr(6'h14, 32'h0);
        repeat (2) @(negedge clk);
        rd(6'h14, s); chk("R9 rx level 3 below 5", int'(s[2]), 0);
        wr(6'h00, K_EN | K_IE | K_AFIE | (32'd3 << 16));
        repeat (2) @(negedge clk);
        rd(6'h14, s); chk("R9 rx level 3 reaches 3", int'(s[2]), 1);
        wr(6'h00, K_EN);
        wr(6'h14, 32'h0);
        rd(6'h0C, s); chk("R4 rx byte 0", int'(s[7:0]), 8'h5A);
        rd(6'h0C, s); chk("R4 rx byte 1", int'(s[7:0]), 8'hC3);
        rd(6'h0C, s); chk("R4 rx byte 2", int'(s[7:0]), 8'h0F);

        // Almost-empty threshold (R9) and flush (R11)
        wr(6'h00, K_EN | K_IE | K_AEIE);
        repeat (2) @(negedge clk);
        rd(6'h14, s); chk("R9 tx level 0 at threshold 0", int'(s[2]), 1);
        wr(6'h10, 32'h1); wr(6'h10, 32'h2);
        wr(6'h14, 32'h0);
        rd(6'h14, s); chk("R9 tx level 2 above threshold", int'(s[2]), 0);
        wr(6'h2C, 32'h1);
        rd(6'h14, s); chk("R11 flush empties tx", int'(s[3]), 1);
        wr(6'h00, K_EN);
        wr(6'h14, 32'h0);

        // Refused byte (R6, R11, R8)
        wr(6'h04, 32'hA0); wr(6'h08, 32'd3);
        nack_idx = 2;
        exp_q.push_back(8'hA0);
        send_byte(8'h11); send_byte(8'h22);
        wr(6'h10, 32'h33);
        run(K_EN | K_IE);
        wait_idle("R6 transfer ends on refusal");
        chk("R6 stop after refusal", stop_cnt, 3);
        rd(6'h14, s); chk("R6 nack and pending set, byte left", int'(s[4:0]), 5'h06);
        wr(6'h2C, 32'h1);
        rd(6'h14, s); chk("R11 flush after refusal", int'(s[3]), 1);
        nack_idx = -1;
        wr(6'h14, 32'h0);
        rd(6'h14, s); chk("R8 nack cleared by zero", int'(s[4:0]), 5'h08);

        // Hold without stop, then repeated start (R5)
        wr(6'h08, 32'd1);
        exp_q.push_back(8'hA0); send_byte(8'h77);
        run(K_EN | K_HOLD);
        wait_idle("R5 held transfer ends");
        repeat (20) @(negedge clk);
        chk("R5 no stop when held", stop_cnt, 3);
        chk("R5 SCL held low", int'(scl_o), 0);
        exp_q.push_back(8'hA0); send_byte(8'h88);
        run(K_EN);
        wait_idle("R5 repeated start transfer");
        chk("R5 stop after repeated start", stop_cnt, 4);

        // Stall on empty transmit queue (R10)
        wr(6'h08, 32'd2);
        exp_q.push_back(8'hA0); send_byte(8'h99);
        run(K_EN);
        repeat (600) @(negedge clk);
        rd(6'h14, s); chk("R10 still busy while starved", int'(s[0]), 1);
        chk("R10 SCL low while starved", int'(scl_o), 0);
        sc = stop_cnt;
        send_byte(8'hAB);
        wait_idle("R10 resumes after push");
        chk("R10 stop after resume", stop_cnt, sc + 1);

        chk("R2 all expected bytes seen", exp_q.size(), 0);
        chk("R4 all ack slots seen", ack_q.size(), 0);
        summary();
    end
endmodule